// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block merges a set of level-sensitive interrupt request lines into one interrupt output for a processor. Software gives each source a 4-bit priority level. A level of zero turns the source off. When any enabled source is requesting, the block raises its interrupt flag. It picks the winning source and records a vector address for that source's handler. The address is built from a software-set table base and a fixed per-source offset.

The recorded vector is frozen for as long as the flag is set. This means a handler can read it and jump without racing against new requests. Software ends the interrupt by writing the flag register. The block then arbitrates again among the requests present at that time. A higher-priority source that arrived during the handler is therefore taken next.

All state is reached through a small single-cycle register bus. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `pvic_top`

## Requirements
- R1: After reset, irq_o is 0, every level register reads 0, the table base reads 0 and the flag register (offset 0x04, bit 0) reads 0.
- R2: A source whose level is 0 never raises the flag and never wins. With no enabled source requesting, irq_o stays 0.
- R3: Among requesting sources with a non-zero level, the one with the numerically highest level wins.
- R4: When several requesting sources share the winning level, the one with the lowest index wins. Source n has vector offset 4*n, so this is the smallest offset.
- R5: The vector register at offset 0x20 reads {base[31:8], 8'(4*winner)}. The table base register at offset 0x00 reads back all 32 written bits, but bits [7:0] do not enter the vector.
- R6: The flag rises at the first clock edge at which an enabled request is present. irq_o equals the flag, and bit 0 at offset 0x04 reads it.
- R7: While the flag stays 1, the vector register does not change, whatever the requests or levels do.
- R8: A write to offset 0x04 with bit 0 = 1 clears the flag at that edge. It wins over a simultaneous set. A write with bit 0 = 0 has no effect. At the next edge the block arbitrates again among the current requests.
- R9: The level register of source n sits at offset 0x40 + 4*n and holds 4 bits. Bits [31:4] read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_SRC | Level-sensitive interrupt requests, bit n = source n |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from bus_addr_i |
| irq_o | output | 1 | Interrupt to the processor (the flag) |

## Verification
Several properties are checked on every cycle by the assertions:
- the vector stays frozen while the flag holds;
- the flag sets when an enabled request is pending and never rises without one;
- a clear always takes effect;
- the arbiter's winner is an enabled, requesting source that no other pending source beats on level or, at equal level, on index.

Other behaviour can only be shown by the bench's sweeps:
- the vector arithmetic seen through the bus;
- the register readback widths and masking;
- the reset values;
- re-arbitration after a clear that picks up a higher-priority source which arrived mid-handler.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int unsigned BUS_AW = 8;
  localparam int unsigned BUS_DW = 32;
  localparam logic [BUS_AW-1:0] A_BASE = 8'h00;
  localparam logic [BUS_AW-1:0] A_FLAG = 8'h04;
  localparam logic [BUS_AW-1:0] A_VEC  = 8'h20;

  // level window 0x40..0x7C, one word per source
  function automatic logic lvl_hit(input logic [BUS_AW-1:0] a);
    return (a[7:6] == 2'b01) && (a[1:0] == 2'b00);
  endfunction
endpackage

// File: rtl/pvic_regs.sv
module pvic_regs
  import pvic_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned LVL_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [BUS_AW-1:0]             addr_i,
  input  logic [BUS_DW-1:0]             wdata_i,
  output logic [N_SRC-1:0][LVL_W-1:0]   lvl_o,
  output logic [BUS_DW-1:0]             base_o,
  output logic                          clr_o
);
  logic [N_SRC-1:0][LVL_W-1:0] lvl_q;
  logic [BUS_DW-1:0]           base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        base_q <= '0;
    else if (wr_i && addr_i == A_BASE)  base_q <= wdata_i;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[g] <= '0;
      else if (wr_i && lvl_hit(addr_i) && addr_i[5:2] == 4'(g))
        lvl_q[g] <= wdata_i[LVL_W-1:0];
    end
  end

  assign clr_o  = wr_i && (addr_i == A_FLAG) && wdata_i[0];
  assign lvl_o  = lvl_q;
  assign base_o = base_q;
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned LVL_W = 4,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_SRC-1:0]            req_i,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
  output logic                        valid_o,
  output logic [IDX_W-1:0]            idx_o
);
  logic [LVL_W-1:0] best;

  // walk downward with >= so an equal level at a lower index takes over
  always_comb begin
    best  = '0;
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i] && lvl_i[i] != '0 && lvl_i[i] >= best) begin
        best  = lvl_i[i];
        idx_o = IDX_W'(i);
      end
    end
    valid_o = (best != '0);
  end

  AST_WIN_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (req_i[idx_o] && lvl_i[idx_o] != '0)); // R2

  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    AST_NOT_BEATEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && req_i[g] && lvl_i[g] != '0) |->
      (lvl_i[g] < lvl_i[idx_o] || (lvl_i[g] == lvl_i[idx_o] && IDX_W'(g) >= idx_o))); // R3 R4
    AST_IDLE_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> !(req_i[g] && lvl_i[g] != '0)); // R2
  end
endmodule

// File: rtl/pvic_core.sv
module pvic_core #(
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned VEC_LSB = 8,
  localparam int unsigned BASE_W = 32 - VEC_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              flag_o,
  output logic [31:0]       vec_o
);
  logic        flag_q;
  logic [31:0] vec_q;
  logic [VEC_LSB-1:0] off;

  assign off = VEC_LSB'({idx_i, 2'b00});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      vec_q  <= '0;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end else if (!flag_q && set_i) begin
      flag_q <= 1'b1;
      vec_q  <= {base_i, off};
    end
  end

  assign flag_o = flag_q;
  assign vec_o  = vec_q;

  AST_VEC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && $past(flag_q)) |-> (vec_q == $past(vec_q))); // R7
  AST_FLAG_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && set_i && !clr_i) |=> flag_q); // R6
  AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set_i)); // R6
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_q); // R8
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int unsigned N_SRC   = 8,
  parameter int unsigned LVL_W   = 4,
  parameter int unsigned VEC_LSB = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic [31:0]                 base;
  logic                        clr, valid, flag;
  logic [IDX_W-1:0]            idx;
  logic [31:0]                 vec;
  logic [3:0]                  sel;

  pvic_regs #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_regs (
    .clk_i, .rst_ni, .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .lvl_o(lvl), .base_o(base), .clr_o(clr)
  );

  pvic_arb #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_arb (
    .clk_i, .rst_ni, .req_i, .lvl_i(lvl), .valid_o(valid), .idx_o(idx)
  );

  pvic_core #(.IDX_W(IDX_W), .VEC_LSB(VEC_LSB)) u_core (
    .clk_i, .rst_ni, .set_i(valid), .clr_i(clr), .idx_i(idx),
    .base_i(base[31:VEC_LSB]), .flag_o(flag), .vec_o(vec)
  );

  assign sel = bus_addr_i[5:2];

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_BASE)      bus_rdata_o = base;
    else if (bus_addr_i == A_FLAG) bus_rdata_o = {31'b0, flag};
    else if (bus_addr_i == A_VEC)  bus_rdata_o = vec;
    else if (lvl_hit(bus_addr_i) && 32'(sel) < N_SRC)
      bus_rdata_o = 32'(lvl[sel[IDX_W-1:0]]);
  end

  assign irq_o = flag;
endmodule

// File: tb/sim_pvic_top.sv
module sim_pvic_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  req_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int checks = 0, errors = 0;
  logic [3:0] lv [8];

  always #2 clk_i = ~clk_i;

  pvic_top u0 (.*);

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #0.5;
    d = bus_rdata_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, base;
    int w, best;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 irq", 32'(irq_o), 0);
    rd(8'h00, d); check("R1 base", d, 0);
    rd(8'h04, d); check("R1 flag", d, 0);
    for (int n = 0; n < 8; n++) begin
      rd(8'(8'h40 + 4*n), d); check("R1 lvl", d, 0);
    end

    // R2 all levels zero: nothing raises the flag
    req_i = 8'hFF;
    repeat (3) @(negedge clk_i);
    check("R2 disabled", 32'(irq_o), 0);
    req_i = '0;

    for (int c = 0; c < 6; c++) begin
      for (int n = 0; n < 8; n++) begin
        lv[n] = 4'((n * (c + 1) + c) % (c + 3));
        wr(8'(8'h40 + 4*n), {28'hABCDEF1, lv[n]});
        rd(8'(8'h40 + 4*n), d); check("R9 lvl readback", d, 32'(lv[n]));
      end
      base = 32'hA5C3_0000 + 32'(c) * 32'h0101_0177;
      wr(8'h00, base);
      rd(8'h00, d); check("R5 base readback", d, base);

      for (int p = 0; p < 256; p++) begin
        req_i = 8'(p);
        #0.5;
        if (p == 1) check("R6 not before edge", 32'(irq_o), 0);
        @(negedge clk_i);
        best = 0; w = -1;
        for (int n = 0; n < 8; n++)
          if (p[n] && int'(lv[n]) > best) begin best = int'(lv[n]); w = n; end
        if (w < 0) begin
          check("R2 no enabled request", 32'(irq_o), 0);
        end else begin
          check("R6 irq", 32'(irq_o), 1);
          rd(8'h04, d); check("R6 flag reg", d, 1);
          rd(8'h20, d); check("R3 R4 R5 vector", d, {base[31:8], 8'(4*w)});
          req_i = ~8'(p);
          @(negedge clk_i);
          rd(8'h20, d); check("R7 frozen", d, {base[31:8], 8'(4*w)});
          if (p == 3) begin
            wr(8'h04, 32'hFFFF_FFFE);
            check("R8 bit0 zero no effect", 32'(irq_o), 1);
          end
        end
        req_i = '0;
        wr(8'h04, 32'h1);
        check("R8 cleared", 32'(irq_o), 0);
      end
    end

    // R8 re-arbitration picks up a higher source that arrived mid-handler
    for (int n = 0; n < 8; n++) wr(8'(8'h40 + 4*n), 32'(n == 2 ? 3 : (n == 6 ? 9 : 0)));
    wr(8'h00, 32'h1234_5600);
    req_i = 8'h04;
    @(negedge clk_i);
    rd(8'h20, d); check("R3 first winner", d, 32'h1234_5608);
    req_i = 8'h44;
    @(negedge clk_i);
    rd(8'h20, d); check("R7 hold with higher pending", d, 32'h1234_5608);
    wr(8'h04, 32'h1);
    check("R8 clear wins over set", 32'(irq_o), 0);
    @(negedge clk_i);
    check("R8 re-raise", 32'(irq_o), 1);
    rd(8'h20, d); check("R8 re-arbitrated vector", d, 32'h1234_5618);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule